// File: doc/BRIEF.md
# Programmable Serial CRC Checker

This block checks a received payload one bit at a time with a cyclic redundancy code whose generator polynomial, starting value, register length and leading skip count are all set through configuration inputs. A frame opens with a start pulse, which loads the starting value and the skip count. Each bit offered with the valid strobe then either uses up one skip slot or, when checking is enabled, advances the shift register. A finish pulse closes the frame. It freezes the remainder and raises a pass flag when the remainder is zero.

The register can be 16, 8 or 4 bits long. The shorter lengths use only the low bits of the register, the polynomial and the starting value. The constant term of the polynomial is always taken as 1, whatever is written in bit 0 of the polynomial input. A transmitter that appends its own remainder after the payload, most significant bit first, gives a zero remainder at the receiver, so the pass flag rises at finish.

Top module: `crc_serial_chk`

## Requirements
- R1: After reset, `crc_o` is 0, `done_o` is 0 and `pass_o` is 0. Bits offered before the first start pulse leave `crc_o` unchanged.
- R2: A start pulse loads `crc_o` with `cfg_init` masked to the active length on the next cycle and clears `done_o` and `pass_o`. A start pulse overrides a finish pulse or a valid bit in the same cycle.
- R3: Each accepted bit computes feedback as the incoming bit XOR the top bit of the active length. The register then shifts left by one. When the feedback is 1, the polynomial is XORed in, with bit 0 of the polynomial forced to 1.
- R4: `cfg_len` selects the length: 2'b00 gives 16 bits, 2'b01 gives 8 bits, 2'b10 gives 4 bits and 2'b11 gives 16 bits. In the 8-bit and 4-bit modes, the bits of `crc_o` above the active length stay 0.
- R5: When `cfg_skip` is N, the first N valid bits after a start pulse leave `crc_o` unchanged. Updating begins with bit N+1.
- R6: While `cfg_crc_en` is 0, valid bits leave `crc_o` unchanged. They still use up skip slots.
- R7: A finish pulse during a frame sets `done_o` on the next cycle. `pass_o` is set to 1 only if `cfg_crc_en` is 1 and the masked remainder is zero. A valid bit offered in the same cycle as the finish pulse is not used. After finish, valid bits leave `crc_o` unchanged and `done_o` stays 1 until the next start pulse.
- R8: A cycle with `bit_vld_i` low leaves `crc_o` unchanged, whatever the value of `bit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_crc_en | input | 1 | Enables CRC updating |
| cfg_poly | input | 16 | Polynomial word. Bit n is the coefficient of x^n; bit 0 is forced to 1 |
| cfg_init | input | 16 | Starting value loaded at start |
| cfg_len | input | 2 | Length select (00: 16, 01: 8, 10: 4, 11: 16) |
| cfg_skip | input | 8 | Number of leading valid bits excluded from the CRC |
| start_i | input | 1 | Frame start pulse |
| finish_i | input | 1 | Frame finish pulse |
| bit_vld_i | input | 1 | Strobe that qualifies `bit_i` |
| bit_i | input | 1 | Received payload bit |
| crc_o | output | 16 | Running remainder |
| done_o | output | 1 | Frame has finished |
| pass_o | output | 1 | Remainder was zero at finish |

## Verification
A wrong tap, a wrong top-bit selection or a polynomial bit 0 that is not forced to 1 changes `crc_o` on the first accepted bit whose feedback is 1. Such an error therefore shows on the port within one cycle and remains in every later value. An off-by-one in the skip counter moves the alignment of the whole payload, so a frame carrying its own remainder fails to reach zero and `pass_o` stays low one cycle after finish. Leakage above the active length shows at once in the upper bits of `crc_o`. A control error, such as updating after finish or while disabled, shows as `crc_o` changing in a cycle where it must hold.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    LEN_FULL = 2'b00,
    LEN_MID  = 2'b01,
    LEN_NIB  = 2'b10,
    LEN_ALT  = 2'b11
  } crc_len_e;

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc_serial_pkg::*;
#(
  parameter int W       = 16,
  parameter int MID_W   = 8,
  parameter int SHORT_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         din,
  input  logic [W-1:0] init,
  input  logic [W-1:0] poly,
  input  crc_len_e     len,
  output logic [W-1:0] crc,
  output logic [W-1:0] mask,
  output logic         rem_zero
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] len_mask(crc_len_e l);
    case (l)
      LEN_MID: len_mask = (ONE << MID_W) - ONE;
      LEN_NIB: len_mask = (ONE << SHORT_W) - ONE;
      default: len_mask = '1;
    endcase
  endfunction

  function automatic logic top_bit(logic [W-1:0] c, crc_len_e l);
    case (l)
      LEN_MID: top_bit = c[MID_W-1];
      LEN_NIB: top_bit = c[SHORT_W-1];
      default: top_bit = c[W-1];
    endcase
  endfunction

  function automatic logic [W-1:0] crc_step(logic [W-1:0] c, logic b,
                                            logic [W-1:0] p, crc_len_e l);
    logic [W-1:0] nxt;
    nxt = c << 1;
    if (top_bit(c, l) ^ b) nxt = nxt ^ (p | ONE);
    crc_step = nxt & len_mask(l);
  endfunction

  assign mask     = len_mask(len);
  assign rem_zero = ((crc & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= '0;
    else if (load) crc <= init & mask;
    else if (step) crc <= crc_step(crc, din, poly, len);
  end

endmodule

// File: rtl/crc_skip_ctr.sv
module crc_skip_ctr #(
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic [SKIP_W-1:0] skip,
  output logic              busy
);

  logic [SKIP_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= skip;
    else if (tick && busy) cnt <= cnt - SKIP_W'(1);
  end

endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic finish,
  input  logic bit_vld,
  input  logic en,
  input  logic rem_zero,
  output logic load_evt,
  output logic bit_acc,
  output logic fin_evt,
  output logic done,
  output logic pass
);

  logic active;

  assign load_evt = start;
  assign fin_evt  = active & finish & ~start;
  assign bit_acc  = active & bit_vld & ~finish & ~start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else if (load_evt) begin
      active <= 1'b1;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else if (fin_evt) begin
      active <= 1'b0;
      done   <= 1'b1;
      pass   <= en & rem_zero;
    end
  end

endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk
  import crc_serial_pkg::*;
#(
  parameter int W       = 16,
  parameter int MID_W   = 8,
  parameter int SHORT_W = 4,
  parameter int SKIP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_crc_en,
  input  logic [W-1:0]      cfg_poly,
  input  logic [W-1:0]      cfg_init,
  input  logic [1:0]        cfg_len,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic              start_i,
  input  logic              finish_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [W-1:0]      crc_o,
  output logic              done_o,
  output logic              pass_o
);

  crc_len_e     len_sel;
  logic         load_evt, bit_acc, fin_evt, skip_busy, upd_en, rem_zero;
  logic [W-1:0] act_mask;

  assign len_sel = crc_len_e'(cfg_len);
  assign upd_en  = bit_acc & ~skip_busy & cfg_crc_en;

  crc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .finish(finish_i),
    .bit_vld(bit_vld_i), .en(cfg_crc_en), .rem_zero(rem_zero),
    .load_evt(load_evt), .bit_acc(bit_acc), .fin_evt(fin_evt),
    .done(done_o), .pass(pass_o)
  );

  crc_skip_ctr #(.SKIP_W(SKIP_W)) u_skip (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .tick(bit_acc),
    .skip(cfg_skip), .busy(skip_busy)
  );

  crc_lfsr #(.W(W), .MID_W(MID_W), .SHORT_W(SHORT_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .step(upd_en), .din(bit_i),
    .init(cfg_init), .poly(cfg_poly), .len(len_sel), .crc(crc_o),
    .mask(act_mask), .rem_zero(rem_zero)
  );

endmodule

// File: rtl/crc_serial_chk_sva.sv
module crc_serial_chk_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_crc_en,
  input logic [W-1:0] cfg_init,
  input logic         start_i,
  input logic         finish_i,
  input logic         bit_vld_i,
  input logic [W-1:0] crc_o,
  input logic         done_o,
  input logic         pass_o,
  input logic         load_evt,
  input logic         bit_acc,
  input logic         skip_busy,
  input logic [W-1:0] act_mask
);

  assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (crc_o == ($past(cfg_init) & $past(act_mask))));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ((crc_o & ~$past(act_mask)) == '0));

  assert_skip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_acc && skip_busy) |=> $stable(crc_o));

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_crc_en && !start_i) |=> $stable(crc_o));

  assert_pass_after_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> $past(finish_i));

  assert_pass_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

  assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(crc_o) && done_o));

  assert_no_strobe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !start_i) |=> $stable(crc_o));

endmodule

bind crc_serial_chk crc_serial_chk_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_crc_en(cfg_crc_en), .cfg_init(cfg_init),
  .start_i(start_i), .finish_i(finish_i), .bit_vld_i(bit_vld_i),
  .crc_o(crc_o), .done_o(done_o), .pass_o(pass_o), .load_evt(load_evt),
  .bit_acc(bit_acc), .skip_busy(skip_busy), .act_mask(act_mask)
);

// File: tb/crc_serial_chk_bench.sv
module crc_serial_chk_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_crc_en = 1'b1;
  logic [15:0] cfg_poly = '0, cfg_init = '0;
  logic [1:0]  cfg_len = 2'b00;
  logic [7:0]  cfg_skip = '0;
  logic        start_i = 1'b0, finish_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [15:0] crc_o;
  logic        done_o, pass_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] crc;
    logic        pass;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  crc_serial_chk u_crc_serial_chk (
    .clk(clk), .rst_n(rst_n), .cfg_crc_en(cfg_crc_en), .cfg_poly(cfg_poly),
    .cfg_init(cfg_init), .cfg_len(cfg_len), .cfg_skip(cfg_skip),
    .start_i(start_i), .finish_i(finish_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .crc_o(crc_o), .done_o(done_o), .pass_o(pass_o)
  );

  function automatic int width_of(logic [1:0] l);
    if (l == 2'b01) return 8;
    if (l == 2'b10) return 4;
    return 16;
  endfunction

  // Independent model: long division one bit at a time, top bit tested
  // by shifting it out of a 17-bit window.
  function automatic logic [15:0] model(logic [15:0] init, logic [15:0] poly,
                                        int w, logic [63:0] v, int n);
    logic [16:0] r;
    logic [16:0] lim;
    lim = 17'(1) << w;
    r = 17'(init) & (lim - 17'd1);
    for (int i = n - 1; i >= 0; i--) begin
      r = r << 1;
      if (((r & lim) != 0) != v[i]) r = r ^ 17'({poly[15:1], 1'b1});
      r = r & (lim - 17'd1);
    end
    return r[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item when done_o rises.
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (done_o && !done_prev) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=unexpected_done expected=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " crc"}, crc_o, e.crc);
        check({e.tag, " pass"}, 16'(pass_o), 16'(e.pass));
      end
    end
    done_prev = done_o;
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      bit_i = v[i]; bit_vld_i = 1'b1;
      @(negedge clk);
    end
    bit_vld_i = 1'b0;
  endtask

  task automatic frame(string tag, logic en, logic [15:0] init, logic [15:0] poly,
                       logic [1:0] len, logic [7:0] skip, logic [63:0] pre,
                       logic [63:0] v, int n);
    exp_t e;
    logic [15:0] m;
    cfg_crc_en = en; cfg_init = init; cfg_poly = poly;
    cfg_len = len; cfg_skip = skip;
    pulse_start();
    send(pre, int'(skip));
    send(v, n);
    m = en ? model(init, poly, width_of(len), v, n)
           : (init & 16'((17'd1 << width_of(len)) - 17'd1));
    e.crc = m; e.pass = en && (m == 16'h0); e.tag = tag;
    sb_q.push_back(e);
    finish_i = 1'b1;
    @(negedge clk); finish_i = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [63:0] with_rem(logic [15:0] init, logic [15:0] poly,
                                           logic [1:0] len, logic [63:0] msg, int n);
    int w;
    w = width_of(len);
    return (msg << w) | 64'(model(init, poly, w, msg, n));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then bits before any start are ignored
    check("R1 crc", crc_o, 16'h0);
    check("R1 done", 16'(done_o), 16'h0);
    check("R1 pass", 16'(pass_o), 16'h0);
    cfg_poly = 16'h1021;
    send(64'hF0F0, 16);
    check("R1 pre-start bits", crc_o, 16'h0);

    // R2 + R4: masked start value in 8-bit mode
    cfg_init = 16'hFFFF; cfg_len = 2'b01;
    pulse_start();
    check("R2/R4 masked init", crc_o, 16'h00FF);

    // R8: strobe low, data toggling
    for (int i = 0; i < 6; i++) begin
      bit_i = i[0]; @(negedge clk);
    end
    check("R8 no strobe", crc_o, 16'h00FF);

    // R3: 16-bit, poly written with bit0 clear (forced to 1), plain message
    frame("R3 crc16 raw", 1'b1, 16'h0000, 16'h1020, 2'b00, 8'd0, 64'h0,
          64'hA5C31F, 24);
    frame("R3 crc16 init", 1'b1, 16'hFFFF, 16'h8004, 2'b11, 8'd0, 64'h0,
          64'h3C5A, 16);

    // R7: frames carrying their own remainder pass
    d = with_rem(16'hFFFF, 16'h1021, 2'b00, 64'h31323334, 32);
    frame("R7 crc16 pass", 1'b1, 16'hFFFF, 16'h1021, 2'b00, 8'd0, 64'h0, d, 48);
    d = with_rem(16'h0000, 16'h0007, 2'b01, 64'hDEADBEEF, 32);
    frame("R4 crc8 pass", 1'b1, 16'hAB00, 16'hFF07, 2'b01, 8'd0, 64'h0, d, 40);
    check("R4 crc8 upper zero", crc_o & 16'hFF00, 16'h0);
    d = with_rem(16'h0005, 16'h0003, 2'b10, 64'h9B7, 12);
    frame("R4 crc4 pass", 1'b1, 16'h0005, 16'h0003, 2'b10, 8'd0, 64'h0, d, 16);

    // R5: skipped garbage prefix still passes
    d = with_rem(16'h1234, 16'h1021, 2'b00, 64'hC0FFEE, 24);
    frame("R5 skip", 1'b1, 16'h1234, 16'h1021, 2'b00, 8'd5, 64'h15, d, 40);

    // R7: corrupted frame fails
    d = with_rem(16'h0, 16'h1021, 2'b00, 64'hC0FFEE, 24) ^ 64'h400;
    frame("R7 corrupt", 1'b1, 16'h0, 16'h1021, 2'b00, 8'd0, 64'h0, d, 40);

    // R6: disabled keeps init, no pass even though init is zero
    frame("R6 disabled", 1'b0, 16'h0000, 16'h1021, 2'b00, 8'd3, 64'h7,
          64'hABCD, 16);

    // R7: bits after finish ignored, done held
    cfg_crc_en = 1'b1;
    held = crc_o;
    send(64'hFFFF, 16);
    check("R7 post-finish crc", crc_o, held);
    check("R7 post-finish done", 16'(done_o), 16'h1);

    // R2: start and finish in the same cycle, start wins
    cfg_init = 16'h5A5A; cfg_len = 2'b00;
    @(negedge clk); start_i = 1'b1; finish_i = 1'b1;
    @(negedge clk); start_i = 1'b0; finish_i = 1'b0;
    check("R2 start wins done", 16'(done_o), 16'h0);
    check("R2 start wins crc", crc_o, 16'h5A5A);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 actual=%0d pending expected=0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule